// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short ordered store of transmit completion records and shows the oldest one to the host as a single status byte. Each time the transmit MAC finishes a frame it presents a one-cycle report with four flags: whether an interrupt was requested on success, jabber, underrun and maximum collisions. The report is appended to the store. The host reads the status byte and retires the oldest record by writing to the status location, which is offset 0xB of register window 1.

The store has a fixed capacity. A report that finds the store full is lost, and the loss is marked in the newest record that is still held. An event output tells the host that the head record needs attention. Jabber and underrun also latch a halt flag that keeps the transmitter stopped until a transmit reset command arrives. That command empties the store as well.

Top module: `txs_stack`

## Requirements
- R1: While the store holds a record, `stat_byte` shows the oldest record as follows: bit 7 = 1 (record present), bit 6 = interrupt request, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow. Bits 1 and 0 are always 0. The byte reflects a report from the cycle after that report is sampled.
- R2: While the store is empty, `stat_byte` reads 0x00. A pop write to an empty store changes nothing.
- R3: Records leave in arrival order. A write (`hw_wr`=1) with `hw_win`=1 and `hw_offs`=0xB removes exactly one record, and the next oldest record appears in the following cycle.
- R4: A write to any other window or offset leaves the store and `stat_byte` unchanged.
- R5: The store holds `DEPTH` records (4 by default). If a report arrives while the store is full and no pop happens in that cycle, the report is discarded and bit 2 is set in the newest stored record. The other records keep their contents.
- R6: If a report and a pop arrive in the same cycle while the store is full, the pop retires the head and the report is stored. No overflow is marked.
- R7: `tx_done_irq` is 1 exactly when the store is non-empty and the head record has any of bits 6..2 set.
- R8: A report carrying jabber or underrun sets `tx_halted` in the next cycle, whether the report is stored or discarded. `tx_halted` then stays at 1 until a transmit reset.
- R9: `tx_reset`=1 empties the store and clears `tx_halted` in the next cycle. It wins over a report or pop in the same cycle, and that report is neither stored nor able to set the halt.
- R10: After `rst_n` is released, `stat_byte`=0x00, `tx_done_irq`=0 and `tx_halted`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid | input | 1 | One-cycle completion report from the transmit MAC |
| rpt_int_req | input | 1 | Report: interrupt on success was requested |
| rpt_jabber | input | 1 | Report: jabber error |
| rpt_underrun | input | 1 | Report: underrun error |
| rpt_max_coll | input | 1 | Report: maximum collisions reached |
| hw_wr | input | 1 | Host write strobe |
| hw_win | input | 3 | Host register window currently selected |
| hw_offs | input | 4 | Host register offset of the write |
| tx_reset | input | 1 | Transmit reset command |
| stat_byte | output | 8 | Oldest completion record, or 0 when the store is empty |
| tx_done_irq | output | 1 | Head record needs host attention |
| tx_halted | output | 1 | Transmitter held off until a transmit reset |

## Verification
The properties assume that the inputs are sampled only at rising edges and that a report lasts exactly one cycle. They also assume that `tx_reset` overrides everything else in its cycle. The stability properties for foreign and empty writes therefore apply only in cycles with no report and no reset. The random stimulus drives inputs on the falling edge and holds every strobe for a single cycle. It mixes target and foreign window/offset pairs and issues resets rarely, so the store often runs full and overflows.

// File: rtl/txs_pkg.sv
package txs_pkg;

    // One completion record as held in the store
    typedef struct packed {
        logic int_req;
        logic jabber;
        logic underrun;
        logic max_coll;
        logic ovf;
    } txs_rec_t;

    // Host-visible byte layout of a record (bit 7 = present, bits 1..0 zero)
    function automatic logic [7:0] txs_format(input logic present, input txs_rec_t r);
        logic [7:0] b;
        b = 8'h00;
        if (present) begin
            b[7] = 1'b1;
            b[6] = r.int_req;
            b[5] = r.jabber;
            b[4] = r.underrun;
            b[3] = r.max_coll;
            b[2] = r.ovf;
        end
        return b;
    endfunction

endpackage

// File: rtl/txs_host_dec.sv
module txs_host_dec #(
    parameter int WIN_W     = 3,
    parameter int OFFS_W    = 4,
    parameter int STAT_WIN  = 1,
    parameter int STAT_OFFS = 11
) (
    input  logic              hw_wr,
    input  logic [WIN_W-1:0]  hw_win,
    input  logic [OFFS_W-1:0] hw_offs,
    output logic              pop_hit
);
    localparam logic [WIN_W-1:0]  WIN_MATCH  = WIN_W'(STAT_WIN);
    localparam logic [OFFS_W-1:0] OFFS_MATCH = OFFS_W'(STAT_OFFS);

    always_comb begin
        pop_hit = hw_wr && (hw_win == WIN_MATCH) && (hw_offs == OFFS_MATCH);
    end
endmodule

// File: rtl/txs_store.sv
module txs_store
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  txs_rec_t         push_rec,
    input  logic             pop,
    output txs_rec_t         head_rec,
    output logic             empty,
    output logic [CNT_W-1:0] occ
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        txs_rec_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     rd;
        logic [PTR_W-1:0]     wr;
        logic [CNT_W-1:0]     cnt;
    } st_t;

    st_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    logic is_full, do_pop, accept, drop;

    always_comb begin
        st_d    = st_q;
        is_full = (st_q.cnt == FULL);
        do_pop  = pop && (st_q.cnt != '0);
        accept  = push && (!is_full || do_pop);
        drop    = push && is_full && !do_pop;
        if (clear) begin
            st_d = '0;
        end else begin
            if (drop) begin
                st_d.mem[ptr_dec(st_q.wr)].ovf = 1'b1;
            end
            if (do_pop) begin
                st_d.rd = ptr_inc(st_q.rd);
            end
            if (accept) begin
                st_d.mem[st_q.wr] = push_rec;
                st_d.wr           = ptr_inc(st_q.wr);
            end
            st_d.cnt = st_q.cnt + CNT_W'(accept) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_rec = st_q.mem[st_q.rd];
    assign empty    = (st_q.cnt == '0);
    assign occ      = st_q.cnt;
endmodule

// File: rtl/txs_halt.sv
module txs_halt (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_reset,
    input  logic rpt_valid,
    input  logic rpt_fatal,
    output logic halted
);
    typedef struct packed {
        logic halted;
    } hs_t;

    hs_t hs_q, hs_d;

    always_comb begin
        hs_d = hs_q;
        if (tx_reset)                    hs_d.halted = 1'b0;
        else if (rpt_valid && rpt_fatal) hs_d.halted = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign halted = hs_q.halted;
endmodule

// File: rtl/txs_stack.sv
module txs_stack
    import txs_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int WIN_W     = 3,
    parameter int OFFS_W    = 4,
    parameter int STAT_WIN  = 1,
    parameter int STAT_OFFS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rpt_valid,
    input  logic              rpt_int_req,
    input  logic              rpt_jabber,
    input  logic              rpt_underrun,
    input  logic              rpt_max_coll,
    input  logic              hw_wr,
    input  logic [WIN_W-1:0]  hw_win,
    input  logic [OFFS_W-1:0] hw_offs,
    input  logic              tx_reset,
    output logic [7:0]        stat_byte,
    output logic              tx_done_irq,
    output logic              tx_halted
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             pop_hit;
    txs_rec_t         new_rec;
    txs_rec_t         head_rec;
    logic             empty;
    logic [CNT_W-1:0] occ;

    txs_host_dec #(
        .WIN_W(WIN_W), .OFFS_W(OFFS_W), .STAT_WIN(STAT_WIN), .STAT_OFFS(STAT_OFFS)
    ) u_dec (
        .hw_wr(hw_wr), .hw_win(hw_win), .hw_offs(hw_offs), .pop_hit(pop_hit)
    );

    always_comb begin
        new_rec.int_req  = rpt_int_req;
        new_rec.jabber   = rpt_jabber;
        new_rec.underrun = rpt_underrun;
        new_rec.max_coll = rpt_max_coll;
        new_rec.ovf      = 1'b0;
    end

    txs_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(tx_reset),
        .push(rpt_valid), .push_rec(new_rec), .pop(pop_hit),
        .head_rec(head_rec), .empty(empty), .occ(occ)
    );

    txs_halt u_halt (
        .clk(clk), .rst_n(rst_n), .tx_reset(tx_reset),
        .rpt_valid(rpt_valid), .rpt_fatal(rpt_jabber | rpt_underrun),
        .halted(tx_halted)
    );

    always_comb begin
        stat_byte   = txs_format(!empty, head_rec);
        tx_done_irq = !empty && (head_rec.int_req || head_rec.jabber ||
                      head_rec.underrun || head_rec.max_coll || head_rec.ovf);
    end
endmodule

// File: rtl/txs_stack_chk.sv
module txs_stack_chk #(
    parameter int DEPTH     = 4,
    parameter int WIN_W     = 3,
    parameter int OFFS_W    = 4,
    parameter int STAT_WIN  = 1,
    parameter int STAT_OFFS = 11,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rpt_valid,
    input logic              rpt_jabber,
    input logic              rpt_underrun,
    input logic              hw_wr,
    input logic [WIN_W-1:0]  hw_win,
    input logic [OFFS_W-1:0] hw_offs,
    input logic              tx_reset,
    input logic [7:0]        stat_byte,
    input logic              tx_done_irq,
    input logic              tx_halted,
    input logic [CNT_W-1:0]  occ
);
    logic target_wr;
    assign target_wr = hw_wr && (hw_win == WIN_W'(STAT_WIN)) && (hw_offs == OFFS_W'(STAT_OFFS));

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[1:0] == 2'b00) else $error("low bits set"); // R1
    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte == 8'h00 && target_wr && !rpt_valid && !tx_reset) |=> stat_byte == 8'h00)
        else $error("empty pop"); // R2
    AST_FOREIGN_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_wr && !target_wr && !rpt_valid && !tx_reset) |=> $stable(stat_byte))
        else $error("foreign write"); // R4
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH)) else $error("occupancy"); // R5
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_irq == (stat_byte[7] && (|stat_byte[6:2]))) else $error("irq"); // R7
    AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && (rpt_jabber || rpt_underrun) && !tx_reset) |=> tx_halted)
        else $error("halt set"); // R8
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_halted && !tx_reset) |=> tx_halted) else $error("halt hold"); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> (stat_byte == 8'h00 && !tx_halted && occ == '0))
        else $error("tx reset"); // R9
endmodule

bind txs_stack txs_stack_chk #(
    .DEPTH(DEPTH), .WIN_W(WIN_W), .OFFS_W(OFFS_W),
    .STAT_WIN(STAT_WIN), .STAT_OFFS(STAT_OFFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_jabber(rpt_jabber),
    .rpt_underrun(rpt_underrun), .hw_wr(hw_wr), .hw_win(hw_win), .hw_offs(hw_offs),
    .tx_reset(tx_reset), .stat_byte(stat_byte), .tx_done_irq(tx_done_irq),
    .tx_halted(tx_halted), .occ(occ)
);

// File: tb/txs_stack_bench.sv
`timescale 1ns/1ps
module txs_stack_bench;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rpt_valid = 0, rpt_int_req = 0, rpt_jabber = 0, rpt_underrun = 0, rpt_max_coll = 0;
    logic       hw_wr = 0;
    logic [2:0] hw_win = 0;
    logic [3:0] hw_offs = 0;
    logic       tx_reset = 0;
    logic [7:0] stat_byte;
    logic       tx_done_irq, tx_halted;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // reference state
    logic [7:0] mq[$];
    bit         m_halt = 0;

    always #2.5 clk = ~clk;

    txs_stack #(.DEPTH(DEPTH)) u_txs_stack (
        .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_int_req(rpt_int_req),
        .rpt_jabber(rpt_jabber), .rpt_underrun(rpt_underrun), .rpt_max_coll(rpt_max_coll),
        .hw_wr(hw_wr), .hw_win(hw_win), .hw_offs(hw_offs), .tx_reset(tx_reset),
        .stat_byte(stat_byte), .tx_done_irq(tx_done_irq), .tx_halted(tx_halted)
    );

    function automatic logic [7:0] exp_byte();
        return (mq.size() == 0) ? 8'h00 : mq[0];
    endfunction

    function automatic bit exp_irq();
        return (mq.size() != 0) && (|mq[0][6:2]);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "stat_byte", stat_byte, exp_byte());
        check("R7", "tx_done_irq", tx_done_irq, exp_irq());
        check("R8", "tx_halted", tx_halted, m_halt);
    endtask

    // drive at a falling edge, update the reference, check at the next falling edge
    task automatic step(string tag, bit v, bit ir, bit jb, bit un, bit mc,
                        bit w, logic [2:0] win, logic [3:0] off, bit rs);
        bit pop, full;
        rpt_valid = v; rpt_int_req = ir; rpt_jabber = jb; rpt_underrun = un; rpt_max_coll = mc;
        hw_wr = w; hw_win = win; hw_offs = off; tx_reset = rs;
        pop  = w && (win == 3'd1) && (off == 4'hB) && (mq.size() > 0);
        full = (mq.size() == DEPTH);
        if (rs) begin
            mq.delete();
            m_halt = 0;
        end else begin
            if (v && (jb || un)) m_halt = 1;
            if (pop) void'(mq.pop_front());
            if (v) begin
                if (!full || pop) mq.push_back({1'b1, ir, jb, un, mc, 1'b0, 2'b00});
                else mq[mq.size()-1][2] = 1'b1;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 3'd0, 4'd0, 0);
    endtask

    task automatic pop1(string tag);
        step(tag, 0, 0, 0, 0, 0, 1, 3'd1, 4'hB, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", "stat_byte", stat_byte, 0);
        check("R10", "tx_done_irq", tx_done_irq, 0);
        check("R10", "tx_halted", tx_halted, 0);

        // R2 pop on empty store
        pop1("R2");
        idle("R2");

        // R1 layout: int_req only -> 0xC0, max coll -> 0x88
        step("R1", 1, 1, 0, 0, 0, 0, 3'd0, 4'd0, 0);
        check("R1", "byte C0", stat_byte, 8'hC0);
        pop1("R1");
        step("R1", 1, 0, 0, 0, 1, 0, 3'd0, 4'd0, 0);
        check("R1", "byte 88", stat_byte, 8'h88);
        pop1("R1");
        step("R1", 1, 0, 0, 0, 0, 0, 3'd0, 4'd0, 0);
        check("R7", "no-error record irq", tx_done_irq, 0);
        pop1("R3");

        // R3 order and R5 overflow: fill with distinct records
        step("R3", 1, 1, 0, 0, 0, 0, 3'd0, 4'd0, 0);
        step("R3", 1, 0, 0, 0, 1, 0, 3'd0, 4'd0, 0);
        step("R3", 1, 1, 0, 0, 1, 0, 3'd0, 4'd0, 0);
        step("R3", 1, 0, 0, 0, 0, 0, 3'd0, 4'd0, 0);
        step("R5", 1, 1, 1, 1, 1, 0, 3'd0, 4'd0, 0);   // dropped, newest gets ovf
        check("R8", "halt from dropped report", tx_halted, 1);
        // R4 foreign writes
        step("R4", 0, 0, 0, 0, 0, 1, 3'd1, 4'hA, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 3'd2, 4'hB, 0);
        check("R4", "head unchanged", stat_byte, 8'hC0);
        // R6 full + report + pop
        step("R6", 1, 0, 0, 1, 0, 1, 3'd1, 4'hB, 0);
        check("R6", "next head", stat_byte, 8'h88);
        pop1("R3");
        check("R3", "third record", stat_byte, 8'hC8);
        pop1("R5");
        check("R5", "overflow marked", stat_byte, 8'h84);
        pop1("R6");
        check("R6", "stored report", stat_byte, 8'h90);
        // R9 reset beats report and pop
        step("R9", 1, 0, 1, 0, 0, 1, 3'd1, 4'hB, 1);
        check("R9", "empty after reset", stat_byte, 0);
        check("R9", "halt cleared", tx_halted, 0);
        idle("R9");

        // random phase
        for (int i = 0; i < 20000; i++) begin
            bit v, ir, jb, un, mc, w, rs;
            logic [2:0] win;
            logic [3:0] off;
            v   = ($urandom % 3) == 0;
            ir  = ($urandom % 3) == 0;
            jb  = ($urandom % 8) == 0;
            un  = ($urandom % 8) == 0;
            mc  = ($urandom % 4) == 0;
            w   = ($urandom % 3) == 0;
            win = (($urandom % 6) == 0) ? 3'($urandom) : 3'd1;
            off = (($urandom % 6) == 0) ? 4'($urandom) : 4'hB;
            rs  = ($urandom % 250) == 0;
            step("R3", v, ir, jb, un, mc, w, win, off, rs);
        end
        finish_run();
    end
endmodule